// File: doc/BRIEF.md
# Pad Deep-Sleep Output Override

This block sits between the pin multiplexer and the pad ring. For every pad it either passes the multiplexed output and output-enable straight through, or replaces them with a sleep value chosen per pad. The replacement is armed by a rising edge on the sleep request. It is not armed by the sleep level. Once armed, the replacement stays in force until software clears it.

Each pad has three pieces of state: an enable bit for sleep behaviour, a two-bit sleep mode and a sticky status bit. At an arming edge, each enabled pad sets its status bit and latches its replacement value into a register. From then on, the pad drives that latched value. Changes on the mux side, a falling sleep request and later configuration writes do not affect it. Software writes 1 to a pad's bit on the clear strobe to return that pad to normal muxed driving. Register access is reduced to plain write strobes.

Top module: `pad_sleep_ovr`

## Requirements
- R1: After reset every pad has sleep enable 0, mode 0 and status 0, so pad outputs equal the mux inputs.
- R2: A pad whose status is 0 drives `pad_out_o`/`pad_oe_o` equal to `mux_out_i`/`mux_oe_i` in the same cycle, with no register in the path.
- R3: A pad is armed only in a cycle where `sleep_req_i` is 1 and was 0 at the previous clock edge, and only if its enable bit is 1. A steady high sleep request arms nothing. Pads with enable 0 keep following the mux.
- R4: Mode code 2'b00 drives output 0 with enable 1 from the cycle after the arming edge.
- R5: Mode code 2'b01 drives output 1 with enable 1 from the cycle after the arming edge.
- R6: Mode code 2'b10 is high-impedance: output 0 and enable 0 from the cycle after the arming edge.
- R7: Mode code 2'b11 keeps the output and enable values that the pad was driving in the cycle of the arming edge.
- R8: While a pad's status is 1 and neither an arming edge nor a clear for it occurs, its output and enable do not change. This holds across mux changes, configuration writes and a falling sleep request.
- R9: With `status_clr_we_i` high, each pad whose bit in `status_clr_wdata_i` is 1 has its status cleared and follows the mux from the next cycle. Pads whose bit is 0 are unaffected.
- R10: If an arming edge and a clear for the same enabled pad occur in the same cycle, the arming wins: status stays 1 and the new value is captured.
- R11: A new arming edge while a pad is already overridden re-captures according to the current mode. In mode 2'b11 this keeps the value already being driven.
- R12: `en_we_i` loads all enable bits from `en_wdata_i`. Bit i of `mode_we_i` loads pad i's mode from `mode_wdata_i[2i+1:2i]`, and modes of pads whose strobe bit is 0 stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Sleep request level; its rising edge arms the override |
| en_we_i | input | 1 | Write strobe for the sleep enable bits |
| en_wdata_i | input | NUM_PADS | New sleep enable bits, one per pad |
| mode_we_i | input | NUM_PADS | Per-pad write strobe for the sleep mode |
| mode_wdata_i | input | 2*NUM_PADS | New sleep modes, two bits per pad, pad i at [2i+1:2i] |
| status_clr_we_i | input | 1 | Write strobe for clearing status bits |
| status_clr_wdata_i | input | NUM_PADS | Write-1-to-clear mask for the status bits |
| mux_out_i | input | NUM_PADS | Output values from the pin multiplexer |
| mux_oe_i | input | NUM_PADS | Output-enable values from the pin multiplexer |
| pad_out_o | output | NUM_PADS | Final pad output values |
| pad_oe_o | output | NUM_PADS | Final pad output-enable values |

## Verification
The properties assume that `sleep_req_i` and all strobes are synchronous to `clk_i` and stable around the sampling edge. They also assume that the sleep request is low while reset is asserted, so the first edge the block sees is an edge the properties also see. The stimulus changes every input only shortly after a rising clock edge. It holds the sleep request low through reset and creates arming edges only by raising a request that was low at the previous edge. It also issues clears and arming edges together to exercise the priority case.

// File: rtl/pad_sleep_pkg.sv
package pad_sleep_pkg;
  typedef enum logic [1:0] {
    SLP_DRIVE0 = 2'b00,
    SLP_DRIVE1 = 2'b01,
    SLP_HIGHZ  = 2'b10,
    SLP_KEEP   = 2'b11
  } slp_mode_e;

  localparam int unsigned ModeW = 2;
endpackage

// File: rtl/pad_sleep_edge.sv
module pad_sleep_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  output logic arm_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= sleep_req_i;
  end

  assign arm_o = sleep_req_i & ~req_q;
endmodule

// File: rtl/pad_sleep_cfg.sv
module pad_sleep_cfg
  import pad_sleep_pkg::*;
#(
  parameter int unsigned NUM_PADS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_we_i,
  input  logic [NUM_PADS-1:0]       en_wdata_i,
  input  logic [NUM_PADS-1:0]       mode_we_i,
  input  logic [ModeW*NUM_PADS-1:0] mode_wdata_i,
  output logic [NUM_PADS-1:0]       en_o,
  output logic [ModeW*NUM_PADS-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_we_i) en_o <= en_wdata_i;
  end

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_o[ModeW*g +: ModeW] <= SLP_DRIVE0;
      else if (mode_we_i[g])
        mode_o[ModeW*g +: ModeW] <= mode_wdata_i[ModeW*g +: ModeW];
    end
  end
endmodule

// File: rtl/pad_sleep_lane.sv
module pad_sleep_lane
  import pad_sleep_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      arm_i,
  input  logic      en_i,
  input  slp_mode_e mode_i,
  input  logic      clr_i,
  input  logic      mux_out_i,
  input  logic      mux_oe_i,
  output logic      pad_out_o,
  output logic      pad_oe_o,
  output logic      status_o
);
  logic hold_out_q, hold_oe_q;
  logic cap_out, cap_oe;

  always_comb begin
    unique case (mode_i)
      SLP_DRIVE0: begin cap_out = 1'b0;      cap_oe = 1'b1;     end
      SLP_DRIVE1: begin cap_out = 1'b1;      cap_oe = 1'b1;     end
      SLP_HIGHZ:  begin cap_out = 1'b0;      cap_oe = 1'b0;     end
      default:    begin cap_out = pad_out_o; cap_oe = pad_oe_o; end
    endcase
  end

  // arming dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o   <= 1'b0;
      hold_out_q <= 1'b0;
      hold_oe_q  <= 1'b0;
    end else if (arm_i && en_i) begin
      status_o   <= 1'b1;
      hold_out_q <= cap_out;
      hold_oe_q  <= cap_oe;
    end else if (clr_i) begin
      status_o   <= 1'b0;
    end
  end

  assign pad_out_o = status_o ? hold_out_q : mux_out_i;
  assign pad_oe_o  = status_o ? hold_oe_q  : mux_oe_i;
endmodule

// File: rtl/pad_sleep_ovr.sv
module pad_sleep_ovr
  import pad_sleep_pkg::*;
#(
  parameter int unsigned NUM_PADS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sleep_req_i,
  input  logic                      en_we_i,
  input  logic [NUM_PADS-1:0]       en_wdata_i,
  input  logic [NUM_PADS-1:0]       mode_we_i,
  input  logic [2*NUM_PADS-1:0]     mode_wdata_i,
  input  logic                      status_clr_we_i,
  input  logic [NUM_PADS-1:0]       status_clr_wdata_i,
  input  logic [NUM_PADS-1:0]       mux_out_i,
  input  logic [NUM_PADS-1:0]       mux_oe_i,
  output logic [NUM_PADS-1:0]       pad_out_o,
  output logic [NUM_PADS-1:0]       pad_oe_o
);
  localparam int unsigned MW = ModeW * NUM_PADS;

  logic                arm;
  logic [NUM_PADS-1:0] cfg_en;
  logic [MW-1:0]       cfg_mode;
  logic [NUM_PADS-1:0] sleep_st;

  pad_sleep_edge i_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .arm_o       (arm)
  );

  pad_sleep_cfg #(.NUM_PADS(NUM_PADS)) i_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_we_i      (en_we_i),
    .en_wdata_i   (en_wdata_i),
    .mode_we_i    (mode_we_i),
    .mode_wdata_i (mode_wdata_i),
    .en_o         (cfg_en),
    .mode_o       (cfg_mode)
  );

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_lane
    pad_sleep_lane i_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arm_i     (arm),
      .en_i      (cfg_en[g]),
      .mode_i    (slp_mode_e'(cfg_mode[ModeW*g +: ModeW])),
      .clr_i     (status_clr_we_i & status_clr_wdata_i[g]),
      .mux_out_i (mux_out_i[g]),
      .mux_oe_i  (mux_oe_i[g]),
      .pad_out_o (pad_out_o[g]),
      .pad_oe_o  (pad_oe_o[g]),
      .status_o  (sleep_st[g])
    );
  end
endmodule

// File: rtl/pad_sleep_ovr_chk.sv
module pad_sleep_ovr_chk #(
  parameter int unsigned NUM_PADS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sleep_req_i,
  input logic                  status_clr_we_i,
  input logic [NUM_PADS-1:0]   status_clr_wdata_i,
  input logic [NUM_PADS-1:0]   mux_out_i,
  input logic [NUM_PADS-1:0]   mux_oe_i,
  input logic [NUM_PADS-1:0]   pad_out_o,
  input logic [NUM_PADS-1:0]   pad_oe_o,
  input logic [NUM_PADS-1:0]   cfg_en,
  input logic [2*NUM_PADS-1:0] cfg_mode,
  input logic [NUM_PADS-1:0]   status
);
  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    p_drive0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sleep_req_i) && cfg_en[g] && cfg_mode[2*g +: 2] == 2'b00
      |=> !pad_out_o[g] && pad_oe_o[g]);

    p_drive1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sleep_req_i) && cfg_en[g] && cfg_mode[2*g +: 2] == 2'b01
      |=> pad_out_o[g] && pad_oe_o[g]);

    p_highz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sleep_req_i) && cfg_en[g] && cfg_mode[2*g +: 2] == 2'b10
      |=> !pad_out_o[g] && !pad_oe_o[g]);

    p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sleep_req_i) && cfg_en[g] && cfg_mode[2*g +: 2] == 2'b11
      |=> pad_out_o[g] == $past(pad_out_o[g]) && pad_oe_o[g] == $past(pad_oe_o[g]));

    p_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status[g] && !$rose(sleep_req_i) && !(status_clr_we_i && status_clr_wdata_i[g])
      |=> $stable(pad_out_o[g]) && $stable(pad_oe_o[g]));

    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status[g] && !$rose(sleep_req_i) && status_clr_we_i && status_clr_wdata_i[g]
      |=> pad_out_o[g] == mux_out_i[g] && pad_oe_o[g] == mux_oe_i[g]);

    p_no_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !status[g] && !$rose(sleep_req_i) |=> !status[g]);
  end
endmodule

bind pad_sleep_ovr pad_sleep_ovr_chk #(.NUM_PADS(NUM_PADS)) i_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .sleep_req_i        (sleep_req_i),
  .status_clr_we_i    (status_clr_we_i),
  .status_clr_wdata_i (status_clr_wdata_i),
  .mux_out_i          (mux_out_i),
  .mux_oe_i           (mux_oe_i),
  .pad_out_o          (pad_out_o),
  .pad_oe_o           (pad_oe_o),
  .cfg_en             (cfg_en),
  .cfg_mode           (cfg_mode),
  .status             (sleep_st)
);

// File: tb/test_pad_sleep_ovr.sv
module test_pad_sleep_ovr;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 1'b0, en_we = 1'b0, clr_we = 1'b0;
  logic [N-1:0] en_wdata = '0, mode_we = '0, clr_wdata = '0;
  logic [2*N-1:0] mode_wdata = '0;
  logic [N-1:0] mux_out = '0, mux_oe = '0, pad_out, pad_oe;

  int total = 0, bad = 0;

  // bench model of the requirements
  logic [N-1:0] m_en = '0, m_st = '0, m_ho = '0, m_hoe = '0;
  logic [1:0]   m_mode [N];
  logic         s_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_sleep_ovr #(.NUM_PADS(N)) i_pad_sleep_ovr (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req),
    .en_we_i(en_we), .en_wdata_i(en_wdata),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .status_clr_we_i(clr_we), .status_clr_wdata_i(clr_wdata),
    .mux_out_i(mux_out), .mux_oe_i(mux_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic logic [N-1:0] exp_out();
    return (m_st & m_ho) | (~m_st & mux_out);
  endfunction
  function automatic logic [N-1:0] exp_oe();
    return (m_st & m_hoe) | (~m_st & mux_oe);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req);
    #1;
    total++;
    if (pad_out !== exp_out() || pad_oe !== exp_oe()) begin
      bad++;
      $display("FAIL %s out=%h exp=%h oe=%h exp=%h", req, pad_out, exp_out(), pad_oe, exp_oe());
    end
  endtask

  task automatic wr_en(input logic [N-1:0] v);
    en_we = 1'b1; en_wdata = v; tick(); en_we = 1'b0; m_en = v;
  endtask

  task automatic wr_mode(input logic [N-1:0] we, input logic [2*N-1:0] v);
    mode_we = we; mode_wdata = v; tick(); mode_we = '0;
    for (int i = 0; i < N; i++) if (we[i]) m_mode[i] = v[2*i +: 2];
  endtask

  task automatic step(input logic s, input logic cw, input logic [N-1:0] cm);
    logic [N-1:0] eo, eoe;
    eo = exp_out(); eoe = exp_oe();
    sleep_req = s; clr_we = cw; clr_wdata = cm;
    if (cw) m_st &= ~cm;
    if (s && !s_prev)
      for (int i = 0; i < N; i++)
        if (m_en[i]) begin
          m_st[i] = 1'b1;
          case (m_mode[i])
            2'b00:   begin m_ho[i] = 1'b0;  m_hoe[i] = 1'b1;   end
            2'b01:   begin m_ho[i] = 1'b1;  m_hoe[i] = 1'b1;   end
            2'b10:   begin m_ho[i] = 1'b0;  m_hoe[i] = 1'b0;   end
            default: begin m_ho[i] = eo[i]; m_hoe[i] = eoe[i]; end
          endcase
        end
    s_prev = s;
    tick();
    clr_we = 1'b0; clr_wdata = '0;
  endtask

  task automatic t_reset();
    mux_out = 8'hA5; mux_oe = 8'h3C;
    chk("R1 reset passthrough");
  endtask

  task automatic t_passthru();
    mux_out = 8'h0F; mux_oe = 8'hF0; chk("R2 pattern a");
    mux_out = 8'hFF; mux_oe = 8'h00; chk("R2 pattern b");
    tick(); mux_out = 8'h66; mux_oe = 8'h99; chk("R2 same-cycle");
  endtask

  task automatic t_level();
    step(1'b1, 1'b0, '0); chk("R3 edge with no pad enabled");
    wr_en(8'hFF);
    mux_out = 8'h3C; mux_oe = 8'hC3; tick(); chk("R3 level high does not arm");
    step(1'b0, 1'b0, '0); chk("R3 fall");
  endtask

  task automatic t_modes();
    wr_en(8'h0F);
    wr_mode(8'h03, 16'hFFF4);   // pad0=00 pad1=01, others not strobed
    wr_mode(8'hFC, 16'h55EC);   // pad2=11? no: pad2=10? set below
    wr_mode(8'h0C, 16'h00E0);   // pad2=10 pad3=11
    mux_out = 8'h5A; mux_oe = 8'h96; chk("R2 before arm");
    step(1'b1, 1'b0, '0);
    chk("R4 R5 R6 R7 R12 modes after edge");
    total++;
    if (pad_out[3:0] !== 4'b1010 || pad_oe[3:0] !== 4'b0011) begin
      bad++;
      $display("FAIL R4-7 literal out=%h oe=%h exp out=a oe=3", pad_out[3:0], pad_oe[3:0]);
    end
  endtask

  task automatic t_stable();
    mux_out = ~mux_out; mux_oe = ~mux_oe; chk("R8 mux change");
    wr_mode(8'hFF, 16'h0000); chk("R8 mode write");
    wr_en(8'h00); chk("R8 enable write");
    step(1'b0, 1'b0, '0); chk("R8 sleep fall");
  endtask

  task automatic t_clear();
    step(1'b0, 1'b1, 8'h05); chk("R9 partial clear");
    step(1'b0, 1'b0, '0); mux_out = 8'h81; chk("R9 cleared pads follow");
    step(1'b0, 1'b1, 8'hFF); chk("R9 clear all");
  endtask

  task automatic t_rearm();
    wr_en(8'h03);
    wr_mode(8'h03, 16'h000F);   // pad0=11 pad1=11
    mux_out = 8'h01; mux_oe = 8'h02;
    step(1'b1, 1'b0, '0); chk("R7 keep captured");
    step(1'b0, 1'b0, '0);
    wr_mode(8'h02, 16'h0008);   // pad1=10
    mux_out = 8'h02; mux_oe = 8'h01;
    step(1'b1, 1'b0, '0); chk("R11 re-arm");
    step(1'b0, 1'b0, '0);
  endtask

  task automatic t_priority();
    wr_mode(8'h01, 16'h0001);   // pad0=01
    mux_out = 8'h00; mux_oe = 8'h00;
    step(1'b1, 1'b1, 8'hFF); chk("R10 arm beats clear");
    step(1'b0, 1'b1, 8'hFF); chk("R9 final clear");
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_mode[i] = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_passthru();
    t_level();
    t_modes();
    t_stable();
    t_clear();
    t_rearm();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule